// File: doc/BRIEF.md
# Datapath Function Unit

This block is the purely combinational compute stage of a small register-file datapath. It receives two operands of parameterised width and a 4-bit operation code, and it returns one result word together with four status flags: overflow, carry, negative and zero. The operation code picks one of three internal paths. These are an adder that handles every arithmetic operation, a bitwise logic unit, and a single-position shifter that acts on the second operand.

In use, the surrounding datapath presents the operands and the code during a cycle. The result and the flags settle within that same cycle and are captured by whatever register lies downstream. The operation code drives the internal selects directly, so no decoding stage sits in front of the block. The top two code bits choose the path, and the low bits choose the operation inside that path.

Top module: `func_unit`

## Requirements
- R1: For codes 0000 to 0111 the result F is A+Y+c, where the low code bit is c and code bits [2:1] pick Y (00: zero, 01: B, 10: ~B, 11: all ones). This gives A, A+1, A+B, A+B+1, A+~B, A-B, A-1 and A, in that order.
- R2: For arithmetic codes C is the carry out of the W-bit addition in R1, that is, bit W of the (W+1)-bit sum.
- R3: For arithmetic codes V is 1 exactly when A and Y have equal most significant bits and the sum's most significant bit differs from them.
- R4: Code 1000 gives A AND B, 1001 gives A OR B, 1010 gives A XOR B, and 1011 gives the bitwise inverse of A.
- R5: Code 1100 passes B unchanged. Code 1101 shifts B right by one and code 1110 shifts B left by one, and in both cases the vacated bit is 0.
- R6: N always equals the most significant bit of F.
- R7: Z is 1 exactly when every bit of F is 0.
- R8: C and V are 0 for every logic code (10xx) and every shifter code (1100 to 1110).
- R9: Code 1111 produces F=0 with V=0, C=0 and N=0. Z follows R7, so it is 1.
- R10: Codes 0110 and 0111 add an all-ones word. So 0111 always yields C=1 with F=A, and 0110 yields C=0 only when A is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | W | Operand A |
| b_in | input | W | Operand B, also the shifter source |
| fsel | input | 4 | Operation code |
| f_out | output | W | Result word |
| v_out | output | 1 | Signed overflow flag |
| c_out | output | 1 | Carry-out flag |
| n_out | output | 1 | Negative flag (result sign bit) |
| z_out | output | 1 | Zero flag |

## Verification
The block holds no state, so every output belongs to the inputs applied in the same cycle and is due zero clock edges after them. The driver changes the operands and the code just after a rising edge and queues the expected result. The monitor takes each queued item at the next falling edge, half a period later, and compares it there, so exactly one vector is in flight at any time. Directed vectors cover the carry and overflow boundaries, the zero-fill shifts and the unused code, and a pseudo-random sweep then spreads operands across all sixteen codes.

// File: rtl/fu_pkg.sv
// Package: fu_pkg
// Shared types and code-field helpers for the datapath function unit.
// Assumes a 4-bit operation code whose top two bits select the path.
package fu_pkg;

    // Which internal path drives the result word
    typedef enum logic [1:0] {
        PATH_ARITH = 2'b00,
        PATH_LOGIC = 2'b01,
        PATH_SHIFT = 2'b10,
        PATH_NONE  = 2'b11
    } path_e;

    // Status flags produced alongside the result
    typedef struct packed {
        logic ovf;
        logic cry;
        logic neg;
        logic zro;
    } fu_flags_t;

    // Map an operation code onto the path that owns it
    function automatic path_e path_of(input logic [3:0] code);
        path_e p;
        if (!code[3])
            p = PATH_ARITH;
        else if (!code[2])
            p = PATH_LOGIC;
        else if (code[1:0] != 2'b11)
            p = PATH_SHIFT;
        else
            p = PATH_NONE;
        return p;
    endfunction

endpackage

// File: rtl/fu_adder.sv
// Module: fu_adder
// Arithmetic path. It adds A, a second operand chosen by sel[2:1] and a carry-in
// taken from sel[0]. It reports the full carry out and the signed overflow.
// Assumes W >= 2. Purely combinational.
module fu_adder #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [2:0]   sel,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] y_op;
    logic [W:0]   wide;

    // Choose the second adder operand from the two middle code bits
    always_comb begin
        unique case (sel[2:1])
            2'b00:   y_op = '0;
            2'b01:   y_op = b;
            2'b10:   y_op = ~b;
            default: y_op = '1;
        endcase
    end

    // One (W+1)-bit addition keeps the carry out as its top bit
    always_comb begin
        wide = {1'b0, a} + {1'b0, y_op} + {{W{1'b0}}, sel[0]};
        sum  = wide[MSB:0];
        cout = wide[W];
    end

    // Overflow: operands agree in sign but the sum does not
    always_comb begin
        ovf = (a[MSB] == y_op[MSB]) && (wide[MSB] != a[MSB]);
    end

endmodule

// File: rtl/fu_logic.sv
// Module: fu_logic
// Bitwise path: AND, OR, XOR, and inversion of A, chosen by sel.
// Purely combinational; the operands are treated as unsigned bit vectors.
module fu_logic #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] y
);
    // Pick the bitwise operation
    always_comb begin
        unique case (sel)
            2'b00:   y = a & b;
            2'b01:   y = a | b;
            2'b10:   y = a ^ b;
            default: y = ~a;
        endcase
    end

endmodule

// File: rtl/fu_shifter.sv
// Module: fu_shifter
// Single-position shifter on operand B, with pass-through, right and left moves.
// The serial inputs are fixed at 0, so a vacated bit always fills with zero.
// Selector 11 has no operation and gives zero. Purely combinational.
module fu_shifter #(
    parameter int W = 16
) (
    input  logic [W-1:0] b,
    input  logic [1:0]   sel,
    output logic [W-1:0] y
);
    localparam int  MSB      = W - 1;
    localparam logic SER_RIGHT = 1'b0;  // enters at the top on a right shift
    localparam logic SER_LEFT  = 1'b0;  // enters at the bottom on a left shift

    logic [W-1:0] shr;
    logic [W-1:0] shl;

    // Build each shifted bit from its neighbour, with the serial inputs at the ends
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == MSB) begin : g_top
            assign shr[i] = SER_RIGHT;
        end else begin : g_mid_r
            assign shr[i] = b[i+1];
        end
        if (i == 0) begin : g_bot
            assign shl[i] = SER_LEFT;
        end else begin : g_mid_l
            assign shl[i] = b[i-1];
        end
    end

    // Per-bit multiplexer on the shift selector
    always_comb begin
        unique case (sel)
            2'b00:   y = b;
            2'b01:   y = shr;
            2'b10:   y = shl;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/func_unit.sv
// Module: func_unit
// Function unit of a register-file datapath. The adder, logic and shifter paths
// run in parallel, and the operation code picks one result and forms the V, C,
// N and Z flags. Carry and overflow come only from the adder path.
// Assumes the caller registers the outputs; the block holds no state.
module func_unit #(
    parameter int W = 16
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [3:0]   fsel,
    output logic [W-1:0] f_out,
    output logic         v_out,
    output logic         c_out,
    output logic         n_out,
    output logic         z_out
);
    import fu_pkg::*;

    localparam int MSB = W - 1;

    logic [W-1:0] add_y;
    logic [W-1:0] log_y;
    logic [W-1:0] sh_y;
    logic         add_c;
    logic         add_v;
    path_e        path;
    fu_flags_t    flg;

    fu_adder #(.W(W)) u_add (
        .a    (a_in),
        .b    (b_in),
        .sel  (fsel[2:0]),
        .sum  (add_y),
        .cout (add_c),
        .ovf  (add_v)
    );

    fu_logic #(.W(W)) u_log (
        .a   (a_in),
        .b   (b_in),
        .sel (fsel[1:0]),
        .y   (log_y)
    );

    fu_shifter #(.W(W)) u_sh (
        .b   (b_in),
        .sel (fsel[1:0]),
        .y   (sh_y)
    );

    // Decode the path from the code's top bits
    always_comb begin
        path = path_of(fsel);
    end

    // Output multiplexer: select the result word
    always_comb begin
        unique case (path)
            PATH_ARITH: f_out = add_y;
            PATH_LOGIC: f_out = log_y;
            PATH_SHIFT: f_out = sh_y;
            default:    f_out = '0;
        endcase
    end

    // Status flags: carry and overflow are gated to the adder path
    always_comb begin
        flg.cry = (path == PATH_ARITH) && add_c;
        flg.ovf = (path == PATH_ARITH) && add_v;
        flg.neg = f_out[MSB];
        flg.zro = ~|f_out;
        v_out   = flg.ovf;
        c_out   = flg.cry;
        n_out   = flg.neg;
        z_out   = flg.zro;
    end

endmodule

// File: rtl/func_unit_chk.sv
// Module: func_unit_chk
// Checker bound to func_unit. It relates the port values under each class of
// code. The block is combinational, so the checks are immediate.
module func_unit_chk #(
    parameter int W = 16
) (
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [3:0]   fsel,
    input logic [W-1:0] f_out,
    input logic         v_out,
    input logic         c_out,
    input logic         n_out,
    input logic         z_out
);
    // Port-level consistency checks, evaluated whenever an input changes
    always_comb begin
        if (fsel == 4'b0000) begin
            assert_pass_a_R1: assert (f_out == a_in && !c_out && !v_out)
                else $error("code 0000 must pass A with clear carry");
        end
        if (fsel == 4'b0111) begin
            assert_ones_carry_R10: assert (f_out == a_in && c_out)
                else $error("code 0111 must pass A with carry set");
        end
        if (fsel[3]) begin
            assert_no_arith_flags_R8: assert (!c_out && !v_out)
                else $error("carry/overflow set outside the adder path");
        end
        if (fsel == 4'b1100) begin
            assert_pass_b_R5: assert (f_out == b_in)
                else $error("code 1100 must pass B");
        end
        if (fsel == 4'b1101) begin
            assert_right_fill_R5: assert (f_out[W-1] == 1'b0 && f_out[W-2:0] == b_in[W-1:1])
                else $error("right shift wrong");
        end
        if (fsel == 4'b1110) begin
            assert_left_fill_R5: assert (f_out[0] == 1'b0 && f_out[W-1:1] == b_in[W-2:0])
                else $error("left shift wrong");
        end
        if (fsel == 4'b1111) begin
            assert_unused_clear_R9: assert (f_out == '0 && !v_out && !c_out && !n_out && z_out)
                else $error("unused code must clear outputs");
        end
        assert_zero_flag_R7: assert (z_out == (f_out == '0))
            else $error("zero flag disagrees with result");
        assert_neg_flag_R6: assert (n_out == f_out[W-1])
            else $error("negative flag disagrees with result");
    end

endmodule

bind func_unit func_unit_chk #(.W(W)) u_chk (
    .a_in  (a_in),
    .b_in  (b_in),
    .fsel  (fsel),
    .f_out (f_out),
    .v_out (v_out),
    .c_out (c_out),
    .n_out (n_out),
    .z_out (z_out)
);

// File: tb/func_unit_tb.sv
`timescale 1ns/1ps
// Scoreboard bench for func_unit: a driver queues expected items and a
// monitor compares them half a cycle after the inputs change.
module func_unit_tb;
    localparam int W = 16;

    typedef struct {
        logic [W-1:0] f;
        logic         v, c, n, z;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [3:0]   fsel = '0;
    logic [W-1:0] f_out;
    logic         v_out, c_out, n_out, z_out;

    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];

    func_unit #(.W(W)) u_dut (
        .a_in (a_in), .b_in (b_in), .fsel (fsel),
        .f_out (f_out), .v_out (v_out), .c_out (c_out),
        .n_out (n_out), .z_out (z_out)
    );

    always #2 clk = ~clk;

    // Reference model written from the requirements
    function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic [3:0] fs, input string tag);
        exp_t e;
        logic [W-1:0] y;
        logic [W:0]   s;
        e.v = 1'b0; e.c = 1'b0; e.tag = tag;
        if (fs[3] == 1'b0) begin
            case (fs[2:1])
                2'd0: y = '0;
                2'd1: y = b;
                2'd2: y = ~b;
                default: y = '1;
            endcase
            s   = {1'b0, a} + {1'b0, y} + (W+1)'(fs[0]);
            e.f = s[W-1:0];
            e.c = s[W];
            e.v = (a[W-1] == y[W-1]) && (s[W-1] != a[W-1]);
        end else begin
            case (fs[2:0])
                3'b000: e.f = a & b;
                3'b001: e.f = a | b;
                3'b010: e.f = a ^ b;
                3'b011: e.f = ~a;
                3'b100: e.f = b;
                3'b101: e.f = b >> 1;
                3'b110: e.f = b << 1;
                default: e.f = '0;
            endcase
        end
        e.n = e.f[W-1];
        e.z = (e.f == '0);
        return e;
    endfunction

    // Driver: apply one vector just after a rising edge and queue its expectation
    task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [3:0] fs, input string tag);
        @(posedge clk);
        #1;
        a_in = a; b_in = b; fsel = fs;
        sb_q.push_back(model(a, b, fs, tag));
    endtask

    // Monitor: outputs are due in the same cycle; compare at the falling edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_run++;
            if (f_out !== e.f || v_out !== e.v || c_out !== e.c ||
                n_out !== e.n || z_out !== e.z) begin
                n_fail++;
                $display("FAIL %s: code=%b a=%h b=%h got F=%h VCNZ=%b%b%b%b exp F=%h VCNZ=%b%b%b%b",
                         e.tag, fsel, a_in, b_in, f_out, v_out, c_out, n_out, z_out,
                         e.f, e.v, e.c, e.n, e.z);
            end
        end
    end

    function automatic string tag_of(input logic [3:0] fs);
        if (!fs[3]) return "R1";
        if (!fs[2]) return "R4";
        if (fs[1:0] != 2'b11) return "R5";
        return "R9";
    endfunction

    initial begin
        logic [W-1:0] lfsr;
        lfsr = 16'hACE1;
        // Idle state: all-zero inputs give a zero result with Z set (R7)
        drive('0, '0, 4'b0000, "R7 idle");
        // R1: every arithmetic code on one pair of operands
        for (int k = 0; k < 8; k++) drive(16'h1234, 16'h0F0F, 4'(k), "R1");
        // R2: carry out of A+1 on all ones and of A+B
        drive(16'hFFFF, 16'h0000, 4'b0001, "R2");
        drive(16'hC000, 16'h8000, 4'b0010, "R2");
        // R3: positive and negative overflow
        drive(16'h7FFF, 16'h0001, 4'b0010, "R3");
        drive(16'h8000, 16'h0001, 4'b0101, "R3");
        drive(16'h8000, 16'h0000, 4'b0110, "R3");
        // R4: logic codes
        for (int k = 8; k < 12; k++) drive(16'hF0A5, 16'h3C3C, 4'(k), "R4");
        // R5: shifts with zero fill on patterns with both end bits set
        drive(16'h0000, 16'h8001, 4'b1100, "R5");
        drive(16'h0000, 16'h8001, 4'b1101, "R5");
        drive(16'h0000, 16'h8001, 4'b1110, "R5");
        drive(16'h0000, 16'hFFFF, 4'b1101, "R5");
        drive(16'h0000, 16'hFFFF, 4'b1110, "R5");
        // R6: a negative result
        drive(16'h0000, 16'h0001, 4'b0101, "R6");
        // R7: subtraction of equal values gives zero
        drive(16'h5A5A, 16'h5A5A, 4'b0101, "R7");
        // R8: logic and shift codes on operands that would carry in the adder
        drive(16'hFFFF, 16'hFFFF, 4'b1001, "R8");
        drive(16'hFFFF, 16'hFFFF, 4'b1110, "R8");
        // R9: unused code with non-zero operands
        drive(16'hFFFF, 16'h8000, 4'b1111, "R9");
        // R10: adding all ones
        drive(16'h0000, 16'h0000, 4'b0110, "R10");
        drive(16'h0005, 16'h0000, 4'b0110, "R10");
        drive(16'h0000, 16'h0000, 4'b0111, "R10");
        drive(16'h9999, 16'h0000, 4'b0111, "R10");
        // Pseudo-random sweep across all codes
        for (int k = 0; k < 400; k++) begin
            logic [W-1:0] ra;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            ra   = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive(ra, lfsr, 4'(k % 16), tag_of(4'(k % 16)));
        end
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule